// File: doc/BRIEF.md
# Scanline-Clocked IRQ Counter

This block counts scanline events down from a value that the CPU programs, and it raises a level interrupt request when the count passes below zero. The CPU reaches it through a plain write port: a 16-bit address, an 8-bit data byte and a write strobe. Only writes in the top quarter of the address space (C000h to FFFFh) are decoded. Inside that window only address bits 13 and 0 choose the register, so the four registers repeat through the window. A separate one-cycle pulse marks each scanline. That pulse comes from logic outside this block.

Four registers control it. The latch register holds the reload value. The reload register copies the latch into the counter. The acknowledge register turns the interrupt off and disables it. The enable register turns the interrupt on. The block keeps two hidden flags. The pending-reload flag lets the next enable write copy the latch into the counter. The reset-mode flag is set by an acknowledge and cleared by the next scanline; while it is set, a latch write also loads the counter directly. The counter is a signed 9-bit value, so a latch of 255 gives 256 scanlines before the interrupt.

The interrupt output comes from a two-state machine. In state IRQ_IDLE the output is low. The transition FIRE moves it to IRQ_RAISED when a scanline takes the counter from 0 to -1 while the block is enabled. The transition ACK returns it to IRQ_IDLE on an acknowledge write. Otherwise the state holds, and an acknowledge in the same cycle as a fire wins.

Top module: `scanline_irq_unit`

## Requirements
- R1: A write acts only when `cpu_addr[15:14]` is 2'b11. Inside that window `{cpu_addr[13], cpu_addr[0]}` picks the register: 00 latch, 01 reload, 10 acknowledge, 11 enable. All other address bits are ignored.
- R2: A latch write stores the data byte. When reset-mode is clear, it also sets pending-reload. When reset-mode is set, it loads the counter with the data byte and clears pending-reload.
- R3: A reload write copies the latch value into the counter.
- R4: An acknowledge write clears the enable flag and sets reset-mode. The interrupt output is low from the next cycle.
- R5: An enable write sets the enable flag. When pending-reload is set, it also copies the latch into the counter.
- R6: Each scanline pulse clears reset-mode, unless an acknowledge write arrives in the same cycle. The pulse decrements a non-negative counter. When the counter goes from 0 to -1 while enabled, `irq_o` rises on the next cycle.
- R7: While the counter is negative, scanline pulses leave it unchanged until a write loads it.
- R8: Once raised, `irq_o` stays high until an acknowledge write or reset. Latch, reload and enable writes and scanline pulses do not lower it.
- R9: Reset clears the counter, the latch, the enable flag, both hidden flags and `irq_o`.
- R10: When a write loads the counter in the same cycle as a scanline pulse, the load wins and the pulse does not decrement.
- R11: The counter holds nine signed bits, so a latch value of 255 lets 255 pulses pass without an interrupt and fires on the 256th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| line_pulse | input | 1 | One-cycle scanline event |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions assume that each write strobe and each scanline pulse lasts exactly one clock. They also assume that the address and data are stable around the sampling edge while the strobe is high. The bench drives every input on the falling edge and holds it for exactly one cycle. It applies writes and pulses one at a time, except in the test of R10, where a reload write and a pulse share a cycle on purpose. The stimulus also uses addresses outside the window and addresses that repeat the registers, so the decode in R1 runs under the same one-cycle assumptions.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

    // Register select formed from address bits {13, 0}
    typedef enum logic [1:0] {
        SEL_LATCH  = 2'b00,
        SEL_RELOAD = 2'b01,
        SEL_ACK    = 2'b10,
        SEL_ENABLE = 2'b11
    } reg_sel_e;

    // Interrupt output state machine
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // One-hot write strobes, one per register
    typedef struct packed {
        logic latch_wr;
        logic reload_wr;
        logic ack_wr;
        logic enable_wr;
    } wr_cmd_t;

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import scanline_irq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output wr_cmd_t           cmd
);
    localparam int TOP = ADDR_W - 1;
    localparam int SEL_BIT = ADDR_W - 3;

    logic     in_window;
    reg_sel_e sel;
    logic     unused_addr;

    assign in_window   = cpu_we && (cpu_addr[TOP -: 2] == 2'b11);
    assign sel         = reg_sel_e'({cpu_addr[SEL_BIT], cpu_addr[0]});
    assign unused_addr = ^cpu_addr[SEL_BIT-1:1];

    always_comb begin
        cmd = '0;
        if (in_window) begin
            unique case (sel)
                SEL_LATCH:  cmd.latch_wr  = 1'b1;
                SEL_RELOAD: cmd.reload_wr = 1'b1;
                SEL_ACK:    cmd.ack_wr    = 1'b1;
                SEL_ENABLE: cmd.enable_wr = 1'b1;
            endcase
        end
    end

    // R1: at most one register strobe per write
    always_comb begin
        p_onehot_sel_r1: assert ($onehot0(cmd));
    end

endmodule

// File: rtl/sirq_counter.sv
module sirq_counter
    import scanline_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  wr_cmd_t                  cmd,
    input  logic [DATA_W-1:0]        cpu_data,
    input  logic                     line_pulse,
    output logic signed [DATA_W:0]   count,
    output logic                     enabled,
    output logic                     reset_mode,
    output logic                     load,
    output logic                     expire
);
    localparam int CNT_W = DATA_W + 1;

    logic [DATA_W-1:0]      latch_q;
    logic                   pending_q;
    logic signed [CNT_W-1:0] load_val;
    logic                   non_neg;

    assign non_neg = ~count[CNT_W-1];

    // A counter load from any of the three write paths
    always_comb begin
        load     = 1'b0;
        load_val = $signed({1'b0, latch_q});
        if (cmd.latch_wr && reset_mode) begin
            load     = 1'b1;
            load_val = $signed({1'b0, cpu_data});
        end else if (cmd.reload_wr) begin
            load = 1'b1;
        end else if (cmd.enable_wr && pending_q) begin
            load = 1'b1;
        end
    end

    // Scanline expiry: counter at zero, pulse not overridden by a load
    assign expire = line_pulse && !load && (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            latch_q    <= '0;
            pending_q  <= 1'b0;
            enabled    <= 1'b0;
            reset_mode <= 1'b0;
        end else begin
            if (cmd.latch_wr) begin
                latch_q   <= cpu_data;
                pending_q <= !reset_mode;
            end

            if (load) begin
                count <= load_val;
            end else if (line_pulse && non_neg) begin
                count <= count - CNT_W'(1);
            end

            if (cmd.ack_wr) begin
                enabled <= 1'b0;
            end else if (cmd.enable_wr) begin
                enabled <= 1'b1;
            end

            if (cmd.ack_wr) begin
                reset_mode <= 1'b1;
            end else if (line_pulse) begin
                reset_mode <= 1'b0;
            end
        end
    end

    // R7: a negative counter does not move without a load
    p_neg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count < 0 && !load) |=> $stable(count));

    // R3: a reload write lands the old latch value in the counter
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.reload_wr && !cmd.latch_wr) |=> (count == $signed({1'b0, $past(latch_q)})));

    // R6: a pulse without an acknowledge leaves reset-mode clear
    p_rm_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && !cmd.ack_wr) |=> !reset_mode);

    // R4: an acknowledge leaves the block disabled and in reset-mode
    p_ack_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.ack_wr |=> (!enabled && reset_mode));

endmodule

// File: rtl/sirq_irq_fsm.sv
module sirq_irq_fsm
    import scanline_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ack,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (fire && !ack) state_d = IRQ_RAISED;   // FIRE
            IRQ_RAISED: if (ack)          state_d = IRQ_IDLE;     // ACK
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    // R4: acknowledge drops the request on the next cycle
    p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq);

    // R8: the request holds until acknowledged
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);

endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit
    import scanline_irq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_we,
    input  logic              line_pulse,
    output logic              irq_o
);
    localparam int CNT_W = DATA_W + 1;

    wr_cmd_t                 cmd;
    logic signed [CNT_W-1:0] count;
    logic                    enabled;
    logic                    reset_mode;
    logic                    load;
    logic                    expire;

    sirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cmd      (cmd)
    );

    sirq_counter #(.DATA_W(DATA_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .cpu_data   (cpu_data),
        .line_pulse (line_pulse),
        .count      (count),
        .enabled    (enabled),
        .reset_mode (reset_mode),
        .load       (load),
        .expire     (expire)
    );

    sirq_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire && enabled),
        .ack   (cmd.ack_wr),
        .irq   (irq_o)
    );

    // R6: expiry while enabled raises the request on the next cycle
    p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && count == 0 && enabled && !load && !cmd.ack_wr) |=> irq_o);

    // R10: a same-cycle load overrides the decrement
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && load) |=> (count >= 0));

endmodule

// File: tb/tb_scanline_irq_unit.sv
module tb_scanline_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic        line_pulse = 1'b0;
    logic        irq_o;

    int vectors = 0;
    int misses = 0;
    string cur_req = "R9";
    bit done = 1'b0;

    // behavioural reference
    int m_cnt = 0, m_latch = 0;
    bit m_en = 0, m_pend = 0, m_rm = 0, m_irq = 0;

    scanline_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_we(cpu_we), .line_pulse(line_pulse), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        bit loaded, acked, old_en, old_rm;
        if (!rst_n) begin
            m_cnt = 0; m_latch = 0; m_en = 0; m_pend = 0; m_rm = 0; m_irq = 0;
        end else begin
            loaded = 0; acked = 0; old_en = m_en; old_rm = m_rm;
            if (cpu_we && (cpu_addr & 16'hC000) == 16'hC000) begin
                case (cpu_addr & 16'hE001)
                    16'hC000: begin
                        m_latch = cpu_data;
                        if (old_rm) begin m_cnt = cpu_data; m_pend = 0; loaded = 1; end
                        else m_pend = 1;
                    end
                    16'hC001: begin m_cnt = m_latch; loaded = 1; end
                    16'hE000: begin m_en = 0; m_irq = 0; m_rm = 1; acked = 1; end
                    default: begin
                        m_en = 1;
                        if (m_pend) begin m_cnt = m_latch; loaded = 1; end
                    end
                endcase
            end
            if (line_pulse) begin
                if (!acked) m_rm = 0;
                if (!loaded && m_cnt >= 0) begin
                    m_cnt = m_cnt - 1;
                    if (m_cnt < 0 && old_en && !acked) m_irq = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (irq_o !== m_irq) begin
                misses++;
                $display("FAIL %s per-cycle irq_o=%0b expected %0b at %0t", cur_req, irq_o, m_irq, $time);
            end
        end
    end

    task automatic chk(input bit exp, input string req);
        vectors++;
        if (irq_o !== exp) begin
            misses++;
            $display("FAIL %s irq_o=%0b expected %0b at %0t", req, irq_o, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            line_pulse = 1'b1;
            @(negedge clk);
            line_pulse = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        idle(3);
        chk(1'b0, "R9");
        rst_n = 1'b1;
        // R9: counter starts at 0, enable with no pending reload, one pulse fires
        wr(16'hE001, 8'h00); pulses(1);
        chk(1'b1, "R9");
        // R8: request holds through other writes and pulses
        cur_req = "R8";
        idle(5); wr(16'hE001, 8'h00); wr(16'hC001, 8'h00); wr(16'hC000, 8'h09); pulses(2);
        chk(1'b1, "R8");
        // R4: acknowledge drops it
        cur_req = "R4";
        wr(16'hE000, 8'h00);
        chk(1'b0, "R4");
        // R2/R3/R5: latch 3 via pending path
        cur_req = "R5";
        pulses(1); wr(16'hC000, 8'h03); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        pulses(3); chk(1'b0, "R3");
        pulses(1); chk(1'b1, "R5");
        // R2: reset-mode direct load of 2
        cur_req = "R2";
        wr(16'hE000, 8'h00); wr(16'hC000, 8'h02); wr(16'hE001, 8'h00);
        pulses(2); chk(1'b0, "R2");
        pulses(1); chk(1'b1, "R2");
        // R7: negative counter, enable without pending reload, pulses do nothing
        cur_req = "R7";
        wr(16'hE000, 8'h00); pulses(1); wr(16'hE001, 8'h00);
        pulses(10); chk(1'b0, "R7");
        // R1: mirrors and out-of-window writes
        cur_req = "R1";
        wr(16'hC000, 8'h00); wr(16'hDFF1, 8'h00);      // latch 0, reload mirror
        wr(16'h7001, 8'h05); wr(16'hBFFF, 8'h07); wr(16'h8000, 8'h44);
        pulses(1); chk(1'b1, "R1");
        wr(16'h6000, 8'h00); wr(16'hA000, 8'h00); wr(16'h3FFE, 8'h00);
        chk(1'b1, "R1");
        wr(16'hF2A6, 8'h00);                             // acknowledge mirror
        chk(1'b0, "R1");
        // R10: reload write and pulse in the same cycle
        cur_req = "R10";
        pulses(1); wr(16'hC000, 8'h01); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
        line_pulse = 1'b1; wr(16'hC001, 8'h00); line_pulse = 1'b0;
        pulses(1); chk(1'b0, "R10");
        pulses(1); chk(1'b1, "R10");
        // R11: latch 255 gives 256 pulses
        cur_req = "R11";
        wr(16'hE000, 8'h00); pulses(1); wr(16'hC000, 8'hFF); wr(16'hC001, 8'h00);
        wr(16'hE001, 8'h00);
        pulses(255); chk(1'b0, "R11");
        pulses(1); chk(1'b1, "R11");
        // R9: reset in mid-run
        cur_req = "R9";
        rst_n = 1'b0; idle(2); chk(1'b0, "R9");
        rst_n = 1'b1;
        wr(16'hE001, 8'h00); pulses(1); chk(1'b1, "R9");
        // R6: acknowledge then pulse, counter stays negative, no fire
        cur_req = "R6";
        wr(16'hE000, 8'h00); pulses(3); chk(1'b0, "R6");
        idle(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule